// File: doc/BRIEF.md
# Display RAM pixel format converter

This block connects an 8-bit host byte port to a display memory whose words hold one pixel each, 12 bits wide: 4 bits of red in the top nibble, 5 bits of green in the middle and 3 bits of blue at the bottom. The host picks one of four input colour depths through a 2-bit format field. The block gathers one, two or three incoming bytes as that format needs, then narrows or widens them into the 12-bit word. It issues the RAM write and steps the shared RAM pointer. One format packs two whole pixels into every three bytes, so it produces two RAM writes per group.

In the other direction, a host read request fetches the pixel at the pointer and hands it back as two bytes. A soft reset returns the format and the pointer to their defaults and drops any partly gathered group. It writes nothing to the RAM. Loading a new format or a new pointer also drops a partial group.

Top module: `pixfmt_conv`

## Requirements
- R1: After reset the format is 00 (so the first byte written is stored at once), the RAM pointer is 0, and no RAM write, RAM read or read-data-valid is active.
- R2: Format 00 takes one byte per pixel, with red in bits 7:5, green in 4:2 and blue in 1:0. The RAM word is {r[2:0], r[2], g[2:0], g[2:1], b[1:0], b[1]}. The word is written in the same cycle as the byte strobe.
- R3: Format 01 takes three bytes A, B, C and performs two writes. The write on byte B stores {A, B[7:4]}. The write on byte C stores {B[3:0], C}.
- R4: Format 10 takes two bytes A, B as a 5-6-5 pixel: red is A[7:3], green is {A[2:0], B[7:5]}, blue is B[4:0]. The write on byte B stores {A[7:4], A[2:0], B[7:6], B[4:2]}.
- R5: Format 11 takes three bytes A, B, C: red is A[7:2], green is B[7:1], blue is C[7:3]. The write on byte C stores {A[7:4], B[7:3], C[7:5]}.
- R6: The RAM address always shows the pointer. The pointer advances by one after each RAM write and after the second byte of each read.
- R7: A read request with no read in progress drives the RAM read enable in that cycle. In the next cycle the read data is valid and carries word[11:4]. A second request returns, one cycle later, {word[3:0], 4'b0000}.
- R8: Loading a format or a pointer discards any partly collected write group and any half-finished read.
- R9: Soft reset sets the format to 00 and the pointer to 0 and discards partial groups. It never writes the RAM, so stored pixels read back unchanged.
- R10: A write or read strobe in the same cycle as a soft reset, format load or pointer load is ignored. When a write and a read strobe coincide, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset command strobe |
| fmt_ld | input | 1 | Load the colour format |
| fmt_in | input | 2 | New colour format |
| ptr_ld | input | 1 | Load the RAM pointer |
| ptr_in | input | ADDR_W | New RAM pointer |
| wr_stb | input | 1 | Host write byte strobe |
| wr_byte | input | 8 | Host write byte |
| rd_req | input | 1 | Host read byte request |
| rd_valid | output | 1 | Read byte valid |
| rd_byte | output | 8 | Read byte |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable (data expected on the next cycle) |
| ram_addr | output | ADDR_W | RAM address (the pointer) |
| ram_wdata | output | 12 | RAM write word |
| ram_rdata | input | 12 | RAM read word |

## Verification
The bench goes after the second write of a format 01 group. A design that shifts the held byte by the wrong amount would store a pixel mixing bits of both pixels. It checks MSB replication in format 00, where zero-filling would give dark, off-level colours. It checks the dropped low bits in formats 10 and 11, where an off-by-one slice would store a pixel one step brighter or would pick up padding bits. It aborts partial groups with format and pointer loads and with a soft reset. A design that kept its byte phase would emit a write one byte early, or at the wrong address. It also probes coinciding strobes and a read-back after a soft reset. Here a faulty priority would write during a control action or would corrupt the RAM contents.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int RED_W  = 4;
   localparam int GRN_W  = 5;
   localparam int BLU_W  = 3;
   localparam int PIX_W  = RED_W + GRN_W + BLU_W;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      FMT_8B  = 2'b00,
      FMT_12B = 2'b01,
      FMT_16B = 2'b10,
      FMT_18B = 2'b11
   } fmt_e;

   typedef logic [PIX_W-1:0]  pix_t;
   typedef logic [BYTE_W-1:0] byte_t;

   function automatic pix_t pack_pix(input logic [RED_W-1:0] r,
                                     input logic [GRN_W-1:0] g,
                                     input logic [BLU_W-1:0] b);
      return {r, g, b};
   endfunction

   // index of the byte that closes a group in each format
   function automatic logic [1:0] group_end(input fmt_e f);
      case (f)
         FMT_8B:  return 2'd0;
         FMT_16B: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/pixfmt_wr_pack.sv
module pixfmt_wr_pack
   import pixfmt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  fmt_e  fmt,
   input  logic  stb,
   input  byte_t din,
   output logic  we,
   output pix_t  word
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [1:0] ph_q;
   logic [1:0] ph_end;
   byte_t      b1_q, b2_q;

   always_comb begin
      ph_end = group_end(fmt);
      we     = 1'b0;
      word   = '0;
      unique case (fmt)
         FMT_8B: begin
            we   = stb;
            word = pack_pix({din[7:5], din[7]}, {din[4:2], din[4:3]}, {din[1:0], din[1]});
         end
         FMT_12B: begin
            we   = stb && (ph_q != 2'd0);
            word = (ph_q == 2'd1) ? {b1_q, din[7:4]} : {b2_q[3:0], din};
         end
         FMT_16B: begin
            we   = stb && (ph_q == ph_end);
            word = pack_pix(b1_q[7:4], {b1_q[2:0], din[7:6]}, din[4:2]);
         end
         default: begin
            we   = stb && (ph_q == ph_end);
            word = pack_pix(b1_q[7:4], b2_q[7:3], din[7:5]);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
         b1_q <= '0;
         b2_q <= '0;
      end else if (clr) begin
         ph_q <= '0;
      end else if (stb) begin
         ph_q <= (ph_q == ph_end) ? 2'd0 : ph_q + 2'd1;
         if (ph_q == 2'd0) b1_q <= din;
         if (ph_q == 2'd1) b2_q <= din;
      end
   end
endmodule

// File: rtl/pixfmt_rd_unpack.sv
module pixfmt_rd_unpack
   import pixfmt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  req,
   input  pix_t  ram_rdata,
   output logic  ram_re,
   output logic  adv,
   output logic  rd_valid,
   output byte_t rd_byte
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int LO_W = PIX_W - BYTE_W;

   logic            busy_q;
   logic            vld_q;
   logic            first_q;
   logic [LO_W-1:0] lo_q;

   assign ram_re   = req && !busy_q;
   assign adv      = req && busy_q;
   assign rd_valid = vld_q;
   assign rd_byte  = first_q ? ram_rdata[PIX_W-1:LO_W]
                             : {lo_q, {(BYTE_W-LO_W){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         vld_q   <= 1'b0;
         first_q <= 1'b0;
         lo_q    <= '0;
      end else begin
         vld_q <= req;
         if (req) first_q <= !busy_q;
         if (clr)      busy_q <= 1'b0;
         else if (req) busy_q <= !busy_q;
         if (vld_q && first_q) lo_q <= ram_rdata[LO_W-1:0];
      end
   end
endmodule

// File: rtl/pixfmt_conv.sv
module pixfmt_conv
   import pixfmt_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter logic [1:0] RESET_FMT = 2'b00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              fmt_ld,
   input  logic [1:0]        fmt_in,
   input  logic              ptr_ld,
   input  logic [ADDR_W-1:0] ptr_in,
   input  logic              wr_stb,
   input  logic [7:0]        wr_byte,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [7:0]        rd_byte,
   output logic              ram_we,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [11:0]       ram_wdata,
   input  logic [11:0]       ram_rdata
);
   timeunit 1ns;
   timeprecision 100ps;

   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
      $error("pixfmt_conv: ADDR_W out of range");
   end
   if (PIX_W != 12 || BYTE_W != 8) begin : g_bad_pix
      $error("pixfmt_conv: pixel or byte width mismatch");
   end

   fmt_e              fmt_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              ctrl;
   logic              wr_ok, rd_ok;
   logic              we_int, adv;

   assign ctrl  = soft_rst || fmt_ld || ptr_ld;
   assign wr_ok = wr_stb && !ctrl;
   assign rd_ok = rd_req && !wr_stb && !ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= fmt_e'(RESET_FMT);
         ptr_q <= '0;
      end else if (soft_rst) begin
         fmt_q <= fmt_e'(RESET_FMT);
         ptr_q <= '0;
      end else begin
         if (fmt_ld) fmt_q <= fmt_e'(fmt_in);
         if (ptr_ld)               ptr_q <= ptr_in;
         else if (we_int || adv)   ptr_q <= ptr_q + 1'b1;
      end
   end

   pixfmt_wr_pack u_wr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctrl),
      .fmt   (fmt_q),
      .stb   (wr_ok),
      .din   (wr_byte),
      .we    (we_int),
      .word  (ram_wdata)
   );

   pixfmt_rd_unpack u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctrl),
      .req       (rd_ok),
      .ram_rdata (ram_rdata),
      .ram_re    (ram_re),
      .adv       (adv),
      .rd_valid  (rd_valid),
      .rd_byte   (rd_byte)
   );

   assign ram_we   = we_int;
   assign ram_addr = ptr_q;
endmodule

// File: rtl/pixfmt_conv_chk.sv
module pixfmt_conv_chk #(
   parameter int ADDR_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              fmt_ld,
   input logic              ptr_ld,
   input logic              wr_stb,
   input logic              rd_req,
   input logic              rd_valid,
   input logic [3:0]        rd_lo,
   input logic              ram_we,
   input logic              ram_re,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [1:0]        fmt_cur
);
   timeunit 1ns;
   timeprecision 100ps;

   assert_fmt00_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_cur == 2'b00 && wr_stb && !soft_rst && !fmt_ld && !ptr_ld) |-> ram_we);

   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> ram_addr == $past(ram_addr) + 1'b1);

   assert_we_has_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> wr_stb);

   assert_valid_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));

   assert_second_byte_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !$past(ram_re)) |-> rd_lo == 4'b0000);

   assert_soft_ptr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ram_addr == '0);

   assert_ctrl_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst || fmt_ld || ptr_ld) |-> (!ram_we && !ram_re));

   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));
endmodule

bind pixfmt_conv pixfmt_conv_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .fmt_ld   (fmt_ld),
   .ptr_ld   (ptr_ld),
   .wr_stb   (wr_stb),
   .rd_req   (rd_req),
   .rd_valid (rd_valid),
   .rd_lo    (rd_byte[3:0]),
   .ram_we   (ram_we),
   .ram_re   (ram_re),
   .ram_addr (ram_addr),
   .fmt_cur  (fmt_q)
);

// File: tb/pixfmt_conv_test.sv
module pixfmt_conv_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0, fmt_ld = 1'b0, ptr_ld = 1'b0;
   logic [1:0]    fmt_in = '0;
   logic [AW-1:0] ptr_in = '0;
   logic          wr_stb = 1'b0, rd_req = 1'b0;
   logic [7:0]    wr_byte = '0;
   logic          rd_valid, ram_we, ram_re;
   logic [7:0]    rd_byte;
   logic [AW-1:0] ram_addr;
   logic [11:0]   ram_wdata;
   logic [11:0]   ram_rdata = '0;

   always #2.5 clk = ~clk;

   pixfmt_conv #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fmt_ld(fmt_ld), .fmt_in(fmt_in),
      .ptr_ld(ptr_ld), .ptr_in(ptr_in), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte), .ram_we(ram_we),
      .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // memory seen by the design
   logic [11:0] ram [0:DEPTH-1];
   always @(posedge clk) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= ram[ram_addr];
   end

   // reference model state
   int          m_fmt, m_ph, m_addr;
   int          m_b1, m_b2;
   int          m_mem [0:DEPTH-1];
   bit          m_rbusy, m_pv, m_pfirst;
   int          m_pix;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int end_of(int f);
      if (f == 0) return 0;
      if (f == 2) return 1;
      return 2;
   endfunction

   function automatic int model_word(int f, int ph, int b1, int b2, int d);
      int r, g, b, g3, b2b;
      case (f)
         0: begin
            g3 = (d >> 2) & 7; b2b = d & 3;
            r = ((d >> 5) * 2) + (d >> 7);
            g = g3 * 4 + (g3 >> 1);
            b = b2b * 2 + (b2b >> 1);
            return r * 256 + g * 8 + b;
         end
         1: return (ph == 1) ? ((b1 * 16) + (d >> 4)) : (((b2 & 15) * 256) + d);
         2: begin
            r = b1 >> 4; g = ((b1 & 7) * 4) + (d >> 6); b = (d >> 2) & 7;
            return r * 256 + g * 8 + b;
         end
         default: begin
            r = b1 >> 4; g = b2 >> 3; b = d >> 5;
            return r * 256 + g * 8 + b;
         end
      endcase
   endfunction

   task automatic step(string req, bit ws, int wb, bit rr, bit ml, int mv, bit al, int av, bit sr);
      bit ctrl, wok, rok, ewe;
      int ew;
      wr_stb = ws; wr_byte = wb[7:0]; rd_req = rr; fmt_ld = ml; fmt_in = mv[1:0];
      ptr_ld = al; ptr_in = av[AW-1:0]; soft_rst = sr;
      #1;
      ctrl = sr || ml || al;
      wok  = ws && !ctrl;
      rok  = rr && !ws && !ctrl;
      ewe  = wok && (m_fmt == 0 || (m_fmt == 1 && m_ph != 0) || m_ph == end_of(m_fmt));
      ew   = model_word(m_fmt, m_ph, m_b1, m_b2, wb);
      chk(req, "ram_we", int'(ram_we), int'(ewe));
      if (ewe) chk(req, "ram_wdata", int'(ram_wdata), ew);
      chk(req, "ram_addr", int'(ram_addr), m_addr);
      chk(req, "ram_re", int'(ram_re), int'(rok && !m_rbusy));
      chk(req, "rd_valid", int'(rd_valid), int'(m_pv));
      if (m_pv)
         chk(req, "rd_byte", int'(rd_byte), m_pfirst ? (m_pix >> 4) : ((m_pix & 15) * 16));
      // advance the model
      if (sr) begin
         m_fmt = 0; m_addr = 0; m_ph = 0; m_rbusy = 0;
      end else begin
         if (ml) begin m_fmt = mv; m_ph = 0; m_rbusy = 0; end
         if (al) begin m_addr = av; m_ph = 0; m_rbusy = 0; end
      end
      if (wok) begin
         if (m_ph == 0) m_b1 = wb;
         if (m_ph == 1) m_b2 = wb;
         m_ph = (m_ph == end_of(m_fmt)) ? 0 : m_ph + 1;
         if (ewe) begin
            m_mem[m_addr] = ew;
            m_addr = (m_addr + 1) % DEPTH;
         end
      end
      m_pv = rok;
      if (rok) begin
         if (!m_rbusy) begin
            m_pix = m_mem[m_addr]; m_pfirst = 1; m_rbusy = 1;
         end else begin
            m_pfirst = 0; m_rbusy = 0; m_addr = (m_addr + 1) % DEPTH;
         end
      end
      @(negedge clk);
   endtask

   task automatic wr(string req, int b);       step(req, 1, b, 0, 0, 0, 0, 0, 0); endtask
   task automatic rd(string req);              step(req, 0, 0, 1, 0, 0, 0, 0, 0); endtask
   task automatic idle(string req);            step(req, 0, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic setfmt(string req, int f);   step(req, 0, 0, 0, 1, f, 0, 0, 0); endtask
   task automatic setptr(string req, int a);   step(req, 0, 0, 0, 0, 0, 1, a, 0); endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; m_mem[i] = 0; end
      m_fmt = 0; m_ph = 0; m_addr = 0; m_b1 = 0; m_b2 = 0;
      m_rbusy = 0; m_pv = 0; m_pfirst = 0; m_pix = 0;
      @(negedge clk); @(negedge clk);
      chk("R1", "ram_we in reset", int'(ram_we), 0);
      chk("R1", "rd_valid in reset", int'(rd_valid), 0);
      chk("R1", "ram_addr in reset", int'(ram_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R1");
      wr("R1", 8'hE5);                       // default format stores at once
      // R2: single-byte pixels, MSB replication
      wr("R2", 8'h00); wr("R2", 8'hFF); wr("R2", 8'h96); wr("R2", 8'h49);
      // R3: two pixels per three bytes
      setptr("R6", 8'h10);
      setfmt("R3", 1);
      wr("R3", 8'hA1); wr("R3", 8'hB2); wr("R3", 8'hC3);
      wr("R3", 8'h3C); wr("R3", 8'h5A); wr("R3", 8'hF0);
      // R4: 5-6-5 truncation
      setfmt("R4", 2);
      wr("R4", 8'hF8); wr("R4", 8'h1F); wr("R4", 8'h7A); wr("R4", 8'hC5);
      // R5: 6-7-5 truncation
      setfmt("R5", 3);
      wr("R5", 8'hFC); wr("R5", 8'hFE); wr("R5", 8'hF8);
      wr("R5", 8'h84); wr("R5", 8'h42); wr("R5", 8'h21);
      // R8: partial groups dropped by format and pointer loads
      wr("R8", 8'h11);
      setfmt("R8", 3);
      wr("R8", 8'hAA); wr("R8", 8'hBB); wr("R8", 8'hCC);
      setfmt("R8", 2);
      wr("R8", 8'h55);
      setptr("R8", 8'h40);
      wr("R8", 8'h66); wr("R8", 8'h77);
      // R10: strobes during control actions, write beats read
      step("R10", 1, 8'h99, 0, 0, 0, 1, 8'h50, 0);
      step("R10", 1, 8'h12, 1, 0, 0, 0, 0, 0);
      step("R10", 1, 8'h34, 1, 0, 0, 0, 0, 0);
      step("R10", 0, 0, 1, 1, 2, 0, 0, 0);
      idle("R10");
      // R7: read back several stored pixels
      setptr("R7", 8'h00);
      for (int i = 0; i < 6; i++) begin rd("R7"); rd("R7"); end
      setptr("R7", 8'h10);
      for (int i = 0; i < 6; i++) begin rd("R6"); idle("R7"); rd("R7"); end
      // R8: half-finished read dropped by a pointer load
      setptr("R8", 8'h12);
      rd("R8");
      setptr("R8", 8'h13);
      rd("R8"); rd("R8"); idle("R8");
      // R9: soft reset mid-group with a coinciding write strobe
      setfmt("R9", 2);
      wr("R9", 8'hDE);
      step("R9", 1, 8'hAD, 0, 0, 0, 0, 0, 1);
      wr("R9", 8'h3C);                       // default format again, pointer 0
      setptr("R9", 8'h01);
      rd("R9"); rd("R9");
      rd("R9"); rd("R9");
      step("R9", 0, 0, 1, 0, 0, 0, 0, 1);
      rd("R9"); rd("R9"); idle("R9");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule